// File: doc/BRIEF.md
# Window Watchdog with Register Feed

This block is a supervision timer for a power-management controller. Software sets it up and keeps it alive through a small register port: a write strobe, a 2-bit address and a byte of data, with read data returned combinationally. Once enabled, the timer checks that feeds arrive before a long timeout runs out. In window mode it also checks that no feed arrives before a short window has passed. A configuration bit chooses what a fault does: it either pulls an active-low reset output low for a fixed number of clocks or only raises a sticky interrupt.

Timing is counted in microsecond ticks. A prescaler makes each tick from `CLK_PER_US` system clocks. The short window is `BASE_US` (11 by default) microseconds shifted left by a 3-bit select. The long timeout is the short window shifted left by one to four places, chosen by a 2-bit ratio field. While the timer runs, software cannot change the timing or the mode. It can still change the enable and the fault action.

Top module: `wdw_watchdog`

## Requirements
- R1: The register map is as follows. Address 0 is configuration: bits 1:0 enable code, bit 2 mode (1 = slow-only, 0 = window), bit 3 action (1 = reset pulse, 0 = interrupt). Address 1 is timing: bits 6:4 short select S, bits 1:0 ratio R. Address 2 is feed: writing 1 to bit 0 is one feed. Address 3 is status: bit 0 is the interrupt flag, and writing 1 to it clears it. Reads return the stored fields with all other bits zero, and the feed address reads 0. After reset every stored field is 0, `irq_o` is 0 and `reset_no` is 1.
- R2: Only enable code 01 runs the timer. With codes 00, 10 and 11 nothing is counted and no fault is raised.
- R3: With no feed, a late fault is taken at the clock edge that completes L = BASE_US·2^S·2^(R+1) ticks after counting restarts. One tick is `CLK_PER_US` clocks. The tick count never reaches L while running.
- R4: In slow-only mode, any feed while running restarts counting from zero and causes no fault.
- R5: In window mode, a feed that arrives while fewer than BASE_US·2^S whole ticks have passed is a fault. A feed at or after that point restarts counting from zero.
- R6: With action 0, a fault sets the sticky interrupt and restarts counting. The flag stays set until a status write clears it. If a fault and a clear fall in the same cycle, the set wins.
- R7: With action 1, a fault drives `reset_no` low for exactly `RST_CYCLES` clocks and leaves the interrupt unchanged. During the pulse nothing is counted and feeds are ignored. Counting starts from zero when the pulse ends.
- R8: While the enable code is 01, writes to the timing register and to the mode bit have no effect, and the read-back keeps the old values. The enable and action bits stay writable.
- R9: Moving the enable code to 01 from any other code starts counting from zero ticks.
- R10: A feed in the same cycle in which the long timeout would expire counts as a feed, not as a late fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Sticky fault interrupt |
| reset_no | output | 1 | Active-low fault reset pulse |

## Verification
The tests sweep the feed time across a range of offsets around the short-window edge in window mode. This separates a feed that is too early from an allowed one, tick by tick. A second sweep moves the feed across the long-timeout edge, which separates a valid late feed from expiry, including the case where both fall in the same cycle. Feeds at a steady pace in slow-only mode, runs with no feed at two timing settings, and the reserved enable codes show that only code 01 counts. Repeated status clears that overlap automatic faults, writes made while the timer is locked, and feeds during a reset pulse cover the priority and the ignore rules.

// File: rtl/wdw_pkg.sv
`timescale 1ns/1ps
package wdw_pkg;
    localparam int DATA_W = 8;
    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_TMO  = 2'd1;
    localparam logic [1:0] ADDR_FEED = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;
    localparam logic [1:0] EN_RUN    = 2'b01;

    typedef struct packed {
        logic       act;   // 1: reset pulse, 0: interrupt
        logic       slow;  // 1: slow-only, 0: window
        logic [1:0] en;
    } cfg_t;

    typedef struct packed {
        logic [2:0] sel;
        logic [1:0] ratio;
    } tmo_t;
endpackage

// File: rtl/wdw_tick.sv
`timescale 1ns/1ps
module wdw_tick #(
    parameter int DIV = 200
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == PW'(DIV - 1));
        if (!run_i || clr_i || tick_o)
            cnt_d = '0;
        else
            cnt_d = cnt_q + PW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    // R3: one tick per DIV clocks, so never two in a row when DIV > 1
    a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
        ((DIV > 1) && tick_o) |=> !tick_o);
endmodule

// File: rtl/wdw_elapsed.sv
`timescale 1ns/1ps
module wdw_elapsed #(
    parameter int BASE_US = 11
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic       tick_i,
    input  logic [2:0] sel_i,
    input  logic [1:0] ratio_i,
    output logic       too_early_o,
    output logic       expire_o
);
    localparam int CW = $clog2((BASE_US << 11) + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] short_lim, long_lim;

    always_comb begin
        short_lim   = CW'(BASE_US) << sel_i;
        long_lim    = short_lim << (3'(ratio_i) + 3'd1);
        too_early_o = cnt_q < short_lim;
        expire_o    = run_i && tick_i && ((cnt_q + CW'(1)) == long_lim);
        if (!run_i || clr_i)
            cnt_d = '0;
        else if (tick_i)
            cnt_d = cnt_q + CW'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    // R3: the elapsed count stays below the long limit while running
    a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i |-> (cnt_q < long_lim));
endmodule

// File: rtl/wdw_watchdog.sv
`timescale 1ns/1ps
module wdw_watchdog
    import wdw_pkg::*;
#(
    parameter int CLK_PER_US = 200,
    parameter int BASE_US    = 11,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              reset_no
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        cfg_t          cfg;
        tmo_t          tmo;
        logic          irq;
        logic [RW-1:0] rstcnt;
    } state_t;

    state_t s_d, s_q;
    logic enabled, pulse, run, feed, tick, too_early, expire;
    logic early_fault, late_fault, fault, feed_ok, restart;
    logic unused_wdata;

    assign unused_wdata = wdata_i[7];

    wdw_tick #(.DIV(CLK_PER_US)) i_tick (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .run_i (run),
        .clr_i (restart),
        .tick_o(tick)
    );

    wdw_elapsed #(.BASE_US(BASE_US)) i_elapsed (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .run_i      (run),
        .clr_i      (restart),
        .tick_i     (tick),
        .sel_i      (s_q.tmo.sel),
        .ratio_i    (s_q.tmo.ratio),
        .too_early_o(too_early),
        .expire_o   (expire)
    );

    always_comb begin
        enabled     = (s_q.cfg.en == EN_RUN);
        pulse       = (s_q.rstcnt != '0);
        run         = enabled && !pulse;
        feed        = wr_en_i && (addr_i == ADDR_FEED) && wdata_i[0];
        early_fault = run && feed && !s_q.cfg.slow && too_early;
        late_fault  = run && !feed && expire;
        fault       = early_fault || late_fault;
        feed_ok     = run && feed && !early_fault;
        restart     = feed_ok || fault;

        s_d = s_q;
        if (pulse)
            s_d.rstcnt = s_q.rstcnt - RW'(1);
        if (wr_en_i && (addr_i == ADDR_CFG)) begin
            if (enabled) begin
                s_d.cfg.en  = wdata_i[1:0];
                s_d.cfg.act = wdata_i[3];
            end else begin
                s_d.cfg = cfg_t'(wdata_i[3:0]);
            end
        end
        if (wr_en_i && (addr_i == ADDR_TMO) && !enabled) begin
            s_d.tmo.sel   = wdata_i[6:4];
            s_d.tmo.ratio = wdata_i[1:0];
        end
        if (wr_en_i && (addr_i == ADDR_STAT) && wdata_i[0])
            s_d.irq = 1'b0;
        if (fault) begin
            if (s_q.cfg.act) s_d.rstcnt = RW'(RST_CYCLES);
            else             s_d.irq    = 1'b1;
        end

        case (addr_i)
            ADDR_CFG: rdata_o = {4'b0, s_q.cfg};
            ADDR_TMO: rdata_o = {1'b0, s_q.tmo.sel, 2'b0, s_q.tmo.ratio};
            ADDR_STAT: rdata_o = {7'b0, s_q.irq};
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign irq_o    = s_q.irq;
    assign reset_no = (s_q.rstcnt == '0);

    // R7: a reset pulse only starts when the reset action was selected
    a_r7_pulse_needs_action: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(reset_no) |-> $past(s_q.cfg.act));
    // R6: the interrupt only rises in interrupt-action mode
    a_r6_irq_needs_action: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_o) |-> !$past(s_q.cfg.act));
    // R2: a stopped timer raises no fault
    a_r2_quiet_when_off: assert property (@(posedge clk_i) disable iff (rst_i)
        (!enabled && !pulse) |=> (reset_no && !$rose(irq_o)));
    // R8: timing fields are frozen while enabled
    a_r8_tmo_locked: assert property (@(posedge clk_i) disable iff (rst_i)
        enabled |=> $stable(s_q.tmo));
endmodule

// File: tb/test_wdw_watchdog.sv
`timescale 1ns/1ps
module test_wdw_watchdog;
    localparam int DIV  = 2;
    localparam int BASE = 11;
    localparam int RSTN = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq, reset_n;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [3:0] m_cfg;
    logic [2:0] m_sel;
    logic [1:0] m_ratio;
    logic       m_irq;
    int         m_pulse, m_cnt;
    int         short_us, long_clk;
    bit         m_en, m_feed, m_fault, m_restart;
    logic [7:0] exp_rd;

    wdw_watchdog #(.CLK_PER_US(DIV), .BASE_US(BASE), .RST_CYCLES(RSTN)) i_wdw_watchdog (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .reset_no(reset_n)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = 4'd0; m_sel = 3'd0; m_ratio = 2'd0; m_irq = 1'b0;
            m_pulse = 0; m_cnt = 0;
        end else begin
            m_en      = (m_cfg[1:0] == 2'b01);
            m_feed    = wr_en && (addr == 2'd2) && wdata[0];
            short_us  = BASE << m_sel;
            long_clk  = (short_us << (m_ratio + 1)) * DIV;
            m_fault   = 1'b0;
            m_restart = 1'b0;
            if (m_pulse > 0) begin
                m_pulse = m_pulse - 1;
                m_cnt = 0;
            end else if (m_en) begin
                if (m_feed) begin
                    if (!m_cfg[2] && (m_cnt / DIV) < short_us) m_fault = 1'b1;
                    else m_restart = 1'b1;
                end else if (m_cnt + 1 == long_clk) begin
                    m_fault = 1'b1;
                end
                if (m_fault || m_restart) m_cnt = 0;
                else m_cnt = m_cnt + 1;
            end else begin
                m_cnt = 0;
            end
            if (wr_en && addr == 2'd3 && wdata[0]) m_irq = 1'b0;
            if (m_fault) begin
                if (m_cfg[3]) m_pulse = RSTN;
                else m_irq = 1'b1;
            end
            if (wr_en && addr == 2'd0) begin
                if (m_en) m_cfg = {wdata[3], m_cfg[2], wdata[1:0]};
                else m_cfg = wdata[3:0];
            end
            if (wr_en && addr == 2'd1 && !m_en) begin
                m_sel = wdata[6:4];
                m_ratio = wdata[1:0];
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            case (addr)
                2'd0: exp_rd = {4'b0, m_cfg};
                2'd1: exp_rd = {1'b0, m_sel, 2'b0, m_ratio};
                2'd3: exp_rd = {7'b0, m_irq};
                default: exp_rd = 8'd0;
            endcase
            vectors++;
            if (reset_n !== (m_pulse == 0) || irq !== m_irq || rdata !== exp_rd) begin
                fails++;
                $display("FAIL %s at %0t: reset_n=%b irq=%b rdata=%h expected reset_n=%b irq=%b rdata=%h",
                         cur_req, $time, reset_n, irq, rdata, (m_pulse == 0), m_irq, exp_rd);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [1:0] a);
        addr = a; idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        // R1: reset state and read-back of each address
        cur_req = "R1";
        for (int a = 0; a < 4; a++) look(2'(a));
        wr(2'd1, 8'h7F); look(2'd1);
        wr(2'd0, 8'hFC); look(2'd0);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        // R2: codes 10 and 11 never count
        cur_req = "R2";
        wr(2'd0, 8'h02); look(2'd3); idle(150);
        wr(2'd0, 8'h03); idle(150);
        wr(2'd0, 8'h00); idle(60);
        // R3: late fault with S=0 R=0, interrupt action, slow mode
        cur_req = "R3";
        wr(2'd0, 8'h05); idle(60);
        // R6: clears overlapping repeated faults
        cur_req = "R6";
        for (int i = 0; i < 120; i++) wr(2'd3, 8'h01);
        idle(50);
        wr(2'd3, 8'h01);
        // R4: steady feeding in slow mode, including very early feeds
        cur_req = "R4";
        wr(2'd0, 8'h00); wr(2'd0, 8'h05);
        wr(2'd2, 8'h01);
        for (int i = 0; i < 10; i++) begin wr(2'd2, 8'h01); idle(30); end
        // R10: feed around long-timeout expiry
        cur_req = "R10";
        for (int off = 36; off < 48; off++) begin
            wr(2'd0, 8'h00); wr(2'd3, 8'h01); wr(2'd0, 8'h05);
            idle(off); wr(2'd2, 8'h01); idle(3);
        end
        // R8: locked timing and mode while enabled
        cur_req = "R8";
        wr(2'd1, 8'h73); look(2'd1);
        wr(2'd0, 8'h01); look(2'd0);
        wr(2'd0, 8'h0D); look(2'd0);
        // R5: window mode, S=1 R=1, sweep around the short edge
        cur_req = "R5";
        wr(2'd0, 8'h00); wr(2'd1, 8'h11);
        for (int off = 38; off < 50; off++) begin
            wr(2'd0, 8'h00); wr(2'd3, 8'h01); wr(2'd0, 8'h01);
            idle(off); wr(2'd2, 8'h01); idle(2); look(2'd3);
        end
        // R7: reset action, late fault, then feeds during the pulse
        cur_req = "R7";
        wr(2'd0, 8'h00); wr(2'd3, 8'h01); wr(2'd1, 8'h00);
        wr(2'd0, 8'h0D); idle(42);
        for (int i = 0; i < 6; i++) wr(2'd2, 8'h01);
        idle(60);
        wr(2'd0, 8'h00); wr(2'd0, 8'h09); idle(5); wr(2'd2, 8'h01); idle(20);
        // R9: restart from zero after disable and re-enable
        cur_req = "R9";
        wr(2'd0, 8'h00); wr(2'd0, 8'h05); idle(30);
        wr(2'd0, 8'h02); idle(10); wr(2'd0, 8'h05); idle(50);
        // R3: longer setting S=2 R=3, slow mode, interrupt action
        cur_req = "R3";
        wr(2'd0, 8'h00); wr(2'd3, 8'h01); wr(2'd1, 8'h23);
        wr(2'd0, 8'h05); idle(1420);
        wr(2'd0, 8'h00);
        look(2'd3);
        finish_run();
    end
endmodule